// File: doc/BRIEF.md
# Burst and Slice DMA Channel

This block is one DMA channel that copies 32-bit words between system memory and one peripheral, with no processor involved once the transfer is under way. Software fills in three registers through a small write/read port: a start address, a block layout (words per block and number of blocks), and a control word that picks the direction, the address stepping and the pacing mode. Setting the start bit in the control word arms the channel. The channel then waits for the peripheral's data request.

Two pacing modes are offered. In burst mode one data request moves the whole programmed transfer, which is words-per-block times number-of-blocks words. In slice mode each data request moves exactly one block, after which the channel waits for the next request. The memory side is a request/grant word bus on which the engine holds its address and data until granted. The peripheral side is a one-cycle strobe per word. The engine clears its busy bit on the last word and raises a one-cycle completion interrupt.

Top module: `dma_chan`

## Requirements
- R1: After reset all three registers read 0, the channel is idle, and `mem_req`, `per_stb` and `irq_done` are low.
- R2: `cfg_sel` 0 selects the start address, 1 selects the block layout, 2 selects the control word, and 3 reads as 0. A write while idle is visible on `cfg_rdata` through the same select.
- R3: A control write while idle with bit 24 set arms the channel. Bit 24 then reads 1 for as long as the transfer runs.
- R4: With control bit 0 set (memory to peripheral), each word is read from memory and then presented on `per_wdata` with a one-cycle `per_stb`, in address order.
- R5: With control bit 0 clear (peripheral to memory), each `per_stb` samples `per_rdata`, and that word is then written to memory in order.
- R6: The first word uses the start address. Each later word is 4 bytes above the previous one, or 4 bytes below it when control bit 1 is set.
- R7: With control bit 9 clear (burst), a single data request moves all size × count words with no further request.
- R8: With control bit 9 set (slice), each data request moves exactly one block of size words. The channel then stays busy and moves nothing until the next request.
- R9: Block layout bits [SIZE_W-1:0] give the words per block, where 0 means 2^SIZE_W. Bits [31:16] give the number of blocks, where 0 means one block.
- R10: While `mem_req` is high and `mem_gnt` is low, the request, address, write data and write enable stay unchanged in the next cycle.
- R11: When the last word completes, bit 24 drops and `irq_done` pulses for exactly one cycle, once per transfer.
- R12: Register writes while the channel is busy are ignored.
- R13: `mem_req` and `per_stb` are never high in the same cycle, and neither is high while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | Peripheral data request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; completes the access |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| per_stb | output | 1 | Peripheral word strobe |
| per_wdata | output | 32 | Word sent to the peripheral |
| per_rdata | input | 32 | Word taken from the peripheral |
| irq_done | output | 1 | Completion interrupt pulse |

## Verification
Several properties are checked by assertions on every cycle:
- the memory request stays steady until it is granted;
- memory and peripheral activity never overlap, and neither occurs while idle;
- busy clears when the transfer finishes, and the interrupt is one cycle wide;
- a slice block ends in the wait state;
- the address moves by exactly one word per step;
- the loaded counts are never zero;
- the configuration does not change while busy.

Other behaviour only the bench scenarios can show. These are the data order and content in both directions, the exact number of words moved per request in each mode, the wrap of a zero block size to a full block, and the readback of registers after writes made while busy.

// File: rtl/dma_chan_pkg.sv
// Shared constants and types for the DMA channel.
// Assumes 32-bit registers; control-word bit positions are fixed here.
package dma_chan_pkg;
    localparam int CTL_DIR_BIT   = 0;   // 1: memory to peripheral
    localparam int CTL_DEC_BIT   = 1;   // 1: address steps down
    localparam int CTL_SLICE_BIT = 9;   // 1: one block per request
    localparam int CTL_BUSY_BIT  = 24;  // start / busy
    localparam int COUNT_LSB     = 16;  // block count field position

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_BLK  = 2'd1;
    localparam logic [1:0] SEL_CTL  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEM  = 2'd2,
        ST_PER  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/dma_chan_regs.sv
// Register file of the channel: start address, block layout, control.
// Writes are accepted only while idle; a control write with the busy bit
// set raises busy and a one-cycle start pulse. Busy drops on finish_i.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int SIZE_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               finish_i,
    output logic               start_o,
    output logic               busy_o,
    output logic [31:0]        base_o,
    output logic [SIZE_W-1:0]  size_o,
    output logic [COUNT_W-1:0] count_o,
    output logic               m2p_o,
    output logic               dec_o,
    output logic               slice_o
);
    localparam logic [31:0] BUSY_MASK = 32'h1 << CTL_BUSY_BIT;

    logic [31:0] base_q, blk_q, ctl_q;
    logic        busy_q, start_q;
    logic        wr_ok;

    assign wr_ok = cfg_we && !busy_q;

    // Register writes, busy tracking and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            blk_q   <= '0;
            ctl_q   <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_ok) begin
                case (cfg_sel)
                    SEL_BASE: base_q <= cfg_wdata;
                    SEL_BLK:  blk_q  <= cfg_wdata;
                    SEL_CTL: begin
                        ctl_q   <= cfg_wdata & ~BUSY_MASK;
                        busy_q  <= cfg_wdata[CTL_BUSY_BIT];
                        start_q <= cfg_wdata[CTL_BUSY_BIT];
                    end
                    default: ;
                endcase
            end else if (finish_i) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Readback multiplexer with live busy bit.
    always_comb begin
        case (cfg_sel)
            SEL_BASE: cfg_rdata = base_q;
            SEL_BLK:  cfg_rdata = blk_q;
            SEL_CTL:  cfg_rdata = ctl_q | (busy_q ? BUSY_MASK : 32'h0);
            default:  cfg_rdata = '0;
        endcase
    end

    assign start_o = start_q;
    assign busy_o  = busy_q;
    assign base_o  = base_q;
    assign size_o  = blk_q[SIZE_W-1:0];
    assign count_o = blk_q[COUNT_LSB +: COUNT_W];
    assign m2p_o   = ctl_q[CTL_DIR_BIT];
    assign dec_o   = ctl_q[CTL_DEC_BIT];
    assign slice_o = ctl_q[CTL_SLICE_BIT];

    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> !busy_q); // R11
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cfg_we) |=> ($stable(base_q) && $stable(blk_q) && $stable(ctl_q))); // R12
endmodule

// File: rtl/dma_chan_cnt.sv
// Address and length counters of the channel.
// Loads on start_i; steps one word per step_i. A zero block size stands
// for 2^SIZE_W words and a zero block count for one block.
module dma_chan_cnt #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SIZE_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [COUNT_W-1:0] count_i,
    input  logic               dec_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               last_word_o,
    output logic               last_block_o
);
    localparam logic [ADDR_W-1:0]  STEP      = ADDR_W'(DATA_W / 8);
    localparam logic [SIZE_W:0]    WORD_ONE  = (SIZE_W+1)'(1);
    localparam logic [COUNT_W:0]   BLOCK_ONE = (COUNT_W+1)'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W:0]   word_left;
    logic [COUNT_W:0]  blk_left;
    logic [SIZE_W:0]   size_eff;
    logic [COUNT_W:0]  count_eff;

    assign size_eff  = (size_i  == '0) ? {1'b1, {SIZE_W{1'b0}}} : {1'b0, size_i};
    assign count_eff = (count_i == '0) ? BLOCK_ONE : {1'b0, count_i};

    // Address stepping and remaining-length bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            word_left <= '0;
            blk_left  <= '0;
        end else if (load_i) begin
            addr_q    <= base_i;
            word_left <= size_eff;
            blk_left  <= count_eff;
        end else if (step_i) begin
            addr_q <= dec_i ? (addr_q - STEP) : (addr_q + STEP);
            if (word_left == WORD_ONE) begin
                word_left <= size_eff;
                blk_left  <= blk_left - BLOCK_ONE;
            end else begin
                word_left <= word_left - WORD_ONE;
            end
        end
    end

    assign addr_o       = addr_q;
    assign last_word_o  = (word_left == WORD_ONE);
    assign last_block_o = (blk_left == BLOCK_ONE);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> ((addr_q == $past(addr_q) + STEP) || (addr_q == $past(addr_q) - STEP))); // R6
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (word_left != '0 && blk_left != '0)); // R9
endmodule

// File: rtl/dma_chan_seq.sv
// Transfer sequencer: waits for a data request, then runs one word at a
// time through a memory access and a peripheral strobe in the order the
// direction needs. Burst continues across blocks; slice returns to wait.
// Assumes the peripheral accepts or supplies a word on every strobe.
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dreq_i,
    input  logic              m2p_i,
    input  logic              slice_i,
    input  logic              last_word_i,
    input  logic              last_block_i,
    input  logic              mem_gnt_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic [DATA_W-1:0] per_rdata_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              per_stb_o,
    output logic [DATA_W-1:0] per_wdata_o,
    output logic              step_o,
    output logic              finish_o,
    output logic              irq_o
);
    seq_state_t        st_q, st_nx, first_st;
    logic [DATA_W-1:0] data_q;
    logic              irq_q;

    assign first_st = m2p_i ? ST_MEM : ST_PER;
    assign step_o   = ((st_q == ST_MEM) && mem_gnt_i && !m2p_i)
                   || ((st_q == ST_PER) && m2p_i);
    assign finish_o = step_o && last_word_i && last_block_i;

    // Next-state selection.
    always_comb begin
        st_nx = st_q;
        case (st_q)
            ST_IDLE: if (start_i) st_nx = ST_WAIT;
            ST_WAIT: if (dreq_i)  st_nx = first_st;
            ST_MEM:  if (mem_gnt_i) st_nx = m2p_i ? ST_PER : ST_IDLE;
            ST_PER:  st_nx = m2p_i ? ST_IDLE : ST_MEM;
            default: st_nx = ST_IDLE;
        endcase
        if (step_o) begin
            if (finish_o)                  st_nx = ST_IDLE;
            else if (last_word_i && slice_i) st_nx = ST_WAIT;
            else                           st_nx = first_st;
        end
    end

    // State, word holding register and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            st_q  <= st_nx;
            irq_q <= finish_o;
            if ((st_q == ST_MEM) && mem_gnt_i && m2p_i)
                data_q <= mem_rdata_i;
            else if ((st_q == ST_PER) && !m2p_i)
                data_q <= per_rdata_i;
        end
    end

    assign mem_req_o   = (st_q == ST_MEM);
    assign mem_we_o    = !m2p_i;
    assign mem_wdata_o = data_q;
    assign per_stb_o   = (st_q == ST_PER);
    assign per_wdata_o = data_q;
    assign irq_o       = irq_q;

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_WAIT) |-> (!mem_req_o && !per_stb_o)); // R13
    AST_SLICE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && last_word_i && !last_block_i && slice_i) |=> (st_q == ST_WAIT)); // R8
endmodule

// File: rtl/dma_chan.sv
// Top of the DMA channel: register file, counters and sequencer.
// Assumes memory read data is valid in the cycle the grant is high.
module dma_chan #(
    parameter int SIZE_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        dreq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic [31:0] mem_rdata,
    output logic        per_stb,
    output logic [31:0] per_wdata,
    input  logic [31:0] per_rdata,
    output logic        irq_done
);
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic               start, busy, finish, step;
    logic               m2p, dec, slice, last_word, last_block;
    logic [ADDR_W-1:0]  base;
    logic [SIZE_W-1:0]  size;
    logic [COUNT_W-1:0] count;

    dma_chan_regs #(.SIZE_W(SIZE_W), .COUNT_W(COUNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .finish_i(finish), .start_o(start), .busy_o(busy),
        .base_o(base), .size_o(size), .count_o(count),
        .m2p_o(m2p), .dec_o(dec), .slice_o(slice)
    );

    dma_chan_cnt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .COUNT_W(COUNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load_i(start), .step_i(step),
        .base_i(base), .size_i(size), .count_i(count), .dec_i(dec),
        .addr_o(mem_addr), .last_word_o(last_word), .last_block_o(last_block)
    );

    dma_chan_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .dreq_i(dreq), .m2p_i(m2p), .slice_i(slice),
        .last_word_i(last_word), .last_block_i(last_block),
        .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata), .per_rdata_i(per_rdata),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
        .per_stb_o(per_stb), .per_wdata_o(per_wdata),
        .step_o(step), .finish_o(finish), .irq_o(irq_done)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we))); // R10
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && per_stb)); // R13
    AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || per_stb) |-> busy); // R13
endmodule

// File: tb/dma_chan_test.sv
// Bench for dma_chan: directed corner cases plus seeded random transfers.
module dma_chan_test;
    localparam int SW = 8;   // reduced block-size width keeps the zero-size case short

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dreq = 1'b0;
    logic        mem_req, mem_we, mem_gnt = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        per_stb;
    logic [31:0] per_wdata, per_rdata = '0;
    logic        irq_done;

    dma_chan #(.SIZE_W(SW), .COUNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .per_stb(per_stb), .per_wdata(per_wdata), .per_rdata(per_rdata),
        .irq_done(irq_done)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:255];
    logic [31:0] cur_base;
    bit cur_m2p, cur_dec;
    int stb_cnt, rd_cnt, wr_cnt, irq_cnt;
    bit irq_prev, hold_prev;
    logic [31:0] prev_addr, prev_wdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int k);
        return cur_dec ? cur_base - 32'(4 * k) : cur_base + 32'(4 * k);
    endfunction

    function automatic logic [31:0] pat(input int k);
        return 32'h5A000000 ^ 32'(k * 13 + 7);
    endfunction

    // Memory and peripheral model, driven and sampled on the falling edge.
    always @(negedge clk) begin
        if (irq_done) begin
            irq_cnt++;
            if (irq_prev) chk(1'b0, "R11 irq wider than one cycle", 32'd1, 32'd0);
        end
        irq_prev = irq_done;
        if (per_stb) begin
            if (cur_m2p)
                chk(per_wdata == mem[exp_addr(stb_cnt)>>2 & 32'hFF], "R4 peripheral word",
                    per_wdata, mem[exp_addr(stb_cnt)>>2 & 32'hFF]);
            stb_cnt++;
        end else begin
            per_rdata = pat(stb_cnt);
        end
        if (mem_req) begin
            if (hold_prev) begin
                chk(mem_addr == prev_addr, "R10 address held", mem_addr, prev_addr);
                chk(mem_wdata == prev_wdata, "R10 data held", mem_wdata, prev_wdata);
            end
            if ($urandom_range(0, 2) != 0) begin
                mem_gnt = 1'b1;
                hold_prev = 1'b0;
                if (mem_we) begin
                    chk(!cur_m2p, "R5 write in wrong direction", 32'd1, 32'd0);
                    chk(mem_addr == exp_addr(wr_cnt), "R6 write address", mem_addr, exp_addr(wr_cnt));
                    chk(mem_wdata == pat(wr_cnt), "R5 write data", mem_wdata, pat(wr_cnt));
                    mem[mem_addr[9:2]] = mem_wdata;
                    wr_cnt++;
                end else begin
                    chk(cur_m2p, "R4 read in wrong direction", 32'd1, 32'd0);
                    chk(mem_addr == exp_addr(rd_cnt), "R6 read address", mem_addr, exp_addr(rd_cnt));
                    mem_rdata = mem[mem_addr[9:2]];
                    rd_cnt++;
                end
            end else begin
                mem_gnt = 1'b0;
                hold_prev = 1'b1;
                prev_addr = mem_addr;
                prev_wdata = mem_wdata;
            end
        end else begin
            mem_gnt = 1'b0;
            hold_prev = 1'b0;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse_dreq();
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        dreq = 1'b0;
    endtask

    function automatic int done_words();
        return cur_m2p ? stb_cnt : wr_cnt;
    endfunction

    task automatic run_xfer(input logic [31:0] base, input int size, input int count,
                            input bit m2p, input bit dec, input bit slice, input bit probe);
        int wpb, nblk, total;
        logic [31:0] ctl, rd;
        wpb = (size == 0) ? (1 << SW) : size;
        nblk = (count == 0) ? 1 : count;
        total = wpb * nblk;
        cur_base = base; cur_m2p = m2p; cur_dec = dec;
        stb_cnt = 0; rd_cnt = 0; wr_cnt = 0; irq_cnt = 0;
        per_rdata = pat(0);
        ctl = (32'(m2p) << 0) | (32'(dec) << 1) | (32'(slice) << 9) | (32'h1 << 24);
        cfg_write(2'd0, base);
        cfg_write(2'd1, {16'(count), 16'(size)});
        cfg_write(2'd2, ctl);
        cfg_read(2'd2, rd);
        chk(rd[24], "R3 busy after start", rd, ctl);
        @(negedge clk);
        if (slice) begin
            for (int b = 0; b < nblk; b++) begin
                pulse_dreq();
                for (int w = 0; w < 5000 && done_words() < wpb * (b + 1); w++) @(negedge clk);
                repeat (12) @(negedge clk);
                chk(done_words() == wpb * (b + 1), "R8 one block per request", done_words(), wpb * (b + 1));
                if (b < nblk - 1) begin
                    cfg_read(2'd2, rd);
                    chk(rd[24] && irq_cnt == 0, "R8 still busy between blocks", rd, ctl);
                    if (probe && b == 0) begin
                        cfg_write(2'd0, 32'h0000_BEE0);
                        cfg_write(2'd1, 32'h0007_0009);
                        cfg_write(2'd2, 32'h0000_0000);
                        cfg_read(2'd0, rd);
                        chk(rd == base, "R12 base locked", rd, base);
                        cfg_read(2'd1, rd);
                        chk(rd == {16'(count), 16'(size)}, "R12 layout locked", rd, {16'(count), 16'(size)});
                        cfg_read(2'd2, rd);
                        chk(rd == ctl, "R12 control locked", rd, ctl);
                    end
                end
            end
        end else begin
            pulse_dreq();
            for (int w = 0; w < 20000 && irq_cnt == 0; w++) @(negedge clk);
            repeat (12) @(negedge clk);
            chk(done_words() == total, "R7 whole transfer on one request", done_words(), total);
            if (size == 0) chk(done_words() == (1 << SW), "R9 zero size is full block", done_words(), 1 << SW);
            if (count == 0) chk(done_words() == wpb, "R9 zero count is one block", done_words(), wpb);
        end
        chk(irq_cnt == 1, "R11 one interrupt", irq_cnt, 1);
        cfg_read(2'd2, rd);
        chk(!rd[24], "R11 busy cleared", rd, ctl & ~32'h0100_0000);
        chk((m2p ? rd_cnt : stb_cnt) == total, m2p ? "R4 word count" : "R5 word count",
            m2p ? rd_cnt : stb_cnt, total);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h01000193 ^ 32'h3C3C1234;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int s = 0; s < 3; s++) begin
            cfg_read(2'(s), rd);
            chk(rd == 32'h0, "R1 register after reset", rd, 32'h0);
        end
        chk(!mem_req && !per_stb && !irq_done, "R1 outputs idle after reset",
            {29'd0, mem_req, per_stb, irq_done}, 32'h0);
        // R2: register map and readback
        cfg_write(2'd0, 32'h1234_5678);
        cfg_read(2'd0, rd); chk(rd == 32'h1234_5678, "R2 base readback", rd, 32'h1234_5678);
        cfg_write(2'd1, 32'h0003_0004);
        cfg_read(2'd1, rd); chk(rd == 32'h0003_0004, "R2 layout readback", rd, 32'h0003_0004);
        cfg_write(2'd2, 32'h0000_0203);
        cfg_read(2'd2, rd); chk(rd == 32'h0000_0203, "R2 control readback", rd, 32'h0000_0203);
        chk(!mem_req && !per_stb, "R13 quiet without start", 32'(mem_req), 32'h0);
        cfg_read(2'd3, rd); chk(rd == 32'h0, "R2 unused select reads zero", rd, 32'h0);
        // Directed transfers
        run_xfer(32'h0000_0100, 4, 3, 1'b1, 1'b0, 1'b0, 1'b0);   // R4 R7 incrementing
        run_xfer(32'h0000_0300, 3, 3, 1'b0, 1'b1, 1'b1, 1'b1);   // R5 R6 R8 R12 decrementing
        run_xfer(32'h0000_0040, 0, 1, 1'b1, 1'b0, 1'b0, 1'b0);   // R9 zero size
        run_xfer(32'h0000_0080, 5, 0, 1'b0, 1'b0, 1'b0, 1'b0);   // R9 zero count
        // Seeded random transfers
        for (int t = 0; t < 8; t++) begin
            run_xfer({20'd0, 12'($urandom) & 12'hFFC}, $urandom_range(1, 6), $urandom_range(0, 4),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        summary();
        $finish;
    end
endmodule